// File: doc/BRIEF.md
# Peripheral Idle and Soft-Reset Controller

This block is the configuration and status front end of a bus peripheral. A 32-bit register port gives access to three words: a fixed revision word, a configuration word and a status word. The configuration word holds a two-bit idle policy, a self-clearing software reset trigger and an automatic clock-gating enable. The status word shows whether a software reset is still in progress.

A power manager raises `idle_req` when it wants the peripheral to go idle. The block answers on `idle_ack` according to the stored policy. It can always acknowledge, never acknowledge, or acknowledge only after the peripheral has been quiet for a full cycle. A software reset holds `sreset_out` high for a fixed number of cycles, and the configuration returns to its reset values during that time. `gate_en` tells the clock-gating cell outside the block when the interface clock may be stopped.

Top module: `pwr_idle_ctrl`

## Requirements
- R1: After reset, the configuration word (offset 0x10) reads 0x0000_0011 (policy 0b10 in bits 4:3, auto-gating bit 0 set), the status word (offset 0x14) reads 0x1, the revision word (offset 0x00) reads the REV_ID parameter, and `idle_ack` and `sreset_out` are low while `gate_en` is high.
- R2: A write to the configuration word without bit 1 set stores bits 4:3 and bit 0. A read returns only those bits, and all other bits read 0.
- R3: Writes to any offset other than 0x10 change no state and start no software reset. A read of an unmapped offset returns 0.
- R4: A configuration write with bit 1 set drives `sreset_out` high for exactly SRST_CYCLES cycles, starting in the cycle after the write. During this window the configuration reads back its reset value 0x11, whatever else was written, and bit 1 always reads 0.
- R5: Status bit 0 reads 0 while `sreset_out` is high and 1 otherwise. Configuration writes made while the software reset runs are ignored.
- R6: With policy 0b00, `idle_ack` rises in the cycle after `idle_req` is seen high, even while `busy_in` is high.
- R7: With policy 0b01, `idle_ack` never rises.
- R8: With policy 0b10, `idle_ack` rises only when `idle_req` is high and the block has been inactive in both the previous and the current cycle. Inactive means no register access, `busy_in` low and no software reset. If activity appears, the acknowledge drops in the following cycle.
- R9: A stored policy of 0b11 reads back as 0b11 and behaves exactly as policy 0b10.
- R10: `idle_ack` is low in any cycle where `idle_req` is low, under every policy.
- R11: With auto-gating set, `gate_en` goes low once no register access has occurred for GATE_QUIET consecutive cycles. It is high in any cycle with an access. With auto-gating clear, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high, else 0 |
| idle_req | input | 1 | Idle request from the power manager |
| idle_ack | output | 1 | Idle acknowledge |
| busy_in | input | 1 | Peripheral has a transaction pending |
| gate_en | output | 1 | 1 keeps the interface clock running, 0 allows gating |
| sreset_out | output | 1 | Module reset pulse produced by a software reset |

## Verification
A wrong idle policy register, or a stale quiet flag, shows up on `idle_ack` in the cycle after the request or the activity change. The bench therefore samples the acknowledge cycle by cycle around each activity edge. A miscounted reset counter changes how many cycles `sreset_out` stays high and how long the status bit reads 0. The bench checks both against the exact cycle count. An off-by-one in the gating counter moves the fall of `gate_en` by one cycle after the last access, so the bench samples every cycle of that window.

// File: rtl/pic_pkg.sv
// Shared encodings for the idle/soft-reset controller.
// Assumes byte offsets and a 32-bit register port.
package pic_pkg;
    localparam int DATA_W = 32;

    // Idle policy encodings; 2'b11 is stored but treated as activity-based.
    typedef enum logic [1:0] {
        IM_ALWAYS = 2'b00,
        IM_NEVER  = 2'b01,
        IM_QUIET  = 2'b10,
        IM_SPARE  = 2'b11
    } idle_mode_e;

    localparam int OFS_REV  = 'h00;
    localparam int OFS_CFG  = 'h10;
    localparam int OFS_STAT = 'h14;

    localparam int MODE_LO  = 3;
    localparam int MODE_HI  = 4;
    localparam int SRST_BIT = 1;
    localparam int AUTO_BIT = 0;

    localparam idle_mode_e MODE_RST = IM_QUIET;
    localparam logic       AUTO_RST = 1'b1;
endpackage

// File: rtl/pic_regs.sv
// Register decode and configuration storage.
// Assumes single-cycle strobes; read data is combinational and 0 when idle.
module pic_regs
    import pic_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [31:0] REV_ID = 32'h0003_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              srst_busy,
    output logic [DATA_W-1:0] reg_rdata,
    output idle_mode_e        mode_q,
    output logic              auto_q,
    output logic              srst_start
);
    logic hit_cfg, hit_stat, hit_rev;

    // Purpose: decode the word being addressed.
    always_comb begin
        hit_cfg  = (reg_addr == ADDR_W'(OFS_CFG));
        hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
        hit_rev  = (reg_addr == ADDR_W'(OFS_REV));
    end

    assign srst_start = reg_wr && hit_cfg && reg_wdata[SRST_BIT] && !srst_busy;

    // Purpose: hold the configuration, forced to defaults by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_start || srst_busy) begin
            mode_q <= MODE_RST;
            auto_q <= AUTO_RST;
        end else if (reg_wr && hit_cfg) begin
            mode_q <= idle_mode_e'(reg_wdata[MODE_HI:MODE_LO]);
            auto_q <= reg_wdata[AUTO_BIT];
        end
    end

    // Purpose: read multiplexer; reserved and trigger bits read 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_rev) begin
                reg_rdata = REV_ID;
            end else if (hit_cfg) begin
                reg_rdata[MODE_HI:MODE_LO] = mode_q;
                reg_rdata[AUTO_BIT]        = auto_q;
            end else if (hit_stat) begin
                reg_rdata[0] = !srst_busy;
            end
        end
    end
endmodule

// File: rtl/pic_sreset.sv
// Software reset sequencer: fixed-length busy window after a start pulse.
// Assumes start is ignored by the caller while busy is high.
module pic_sreset #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/pic_idle.sv
// Idle handshake: answers idle_req per the stored policy.
// Assumes 'active' covers every source of internal activity.
module pic_idle
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  idle_mode_e mode,
    input  logic       idle_req,
    input  logic       active,
    output logic       idle_ack
);
    logic quiet_q, ack_q;

    // Purpose: remember whether the previous cycle was inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= 1'b0;
        else        quiet_q <= !active;
    end

    // Purpose: register the policy decision for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            unique case (mode)
                IM_ALWAYS: ack_q <= idle_req;
                IM_NEVER:  ack_q <= 1'b0;
                default:   ack_q <= idle_req && quiet_q && !active;
            endcase
        end
    end

    assign idle_ack = ack_q && idle_req;
endmodule

// File: rtl/pic_gate.sv
// Clock-gating enable: allows gating after QUIET access-free cycles.
// Assumes the external cell stops the clock while gate_en is low.
module pic_gate #(
    parameter int QUIET = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic auto_en,
    output logic gate_en
);
    localparam int CW = $clog2(QUIET + 1);

    logic [CW-1:0] quiet_cnt;

    // Purpose: saturating count of cycles without a register access.
    always_ff @(posedge clk) begin
        if (!rst_n || access) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != CW'(QUIET)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign gate_en = !(auto_en && (quiet_cnt == CW'(QUIET)) && !access);
endmodule

// File: rtl/pwr_idle_ctrl.sv
// Top level: register port, soft reset, idle handshake and gating enable.
// Assumes one register access per cycle and a synchronous active-low reset.
module pwr_idle_ctrl
    import pic_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] REV_ID      = 32'h0003_0102,
    parameter int          SRST_CYCLES = 8,
    parameter int          GATE_QUIET  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              idle_req,
    output logic              idle_ack,
    input  logic              busy_in,
    output logic              gate_en,
    output logic              sreset_out
);
    idle_mode_e mode_q;
    logic       auto_q, srst_start, srst_busy, access, active;

    assign access     = reg_wr || reg_rd;
    assign active     = access || busy_in || srst_busy;
    assign sreset_out = srst_busy;

    pic_regs #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
        .srst_busy, .reg_rdata, .mode_q, .auto_q, .srst_start
    );

    pic_sreset #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk, .rst_n, .start(srst_start), .busy(srst_busy)
    );

    pic_idle u_idle (
        .clk, .rst_n, .mode(mode_q), .idle_req, .active, .idle_ack
    );

    pic_gate #(.QUIET(GATE_QUIET)) u_gate (
        .clk, .rst_n, .access, .auto_en(auto_q), .gate_en
    );
endmodule

// File: rtl/pic_checker.sv
// Property checker for pwr_idle_ctrl, attached by bind below.
module pic_checker
    import pic_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              idle_req,
    input logic              idle_ack,
    input logic              busy_in,
    input logic              gate_en,
    input logic              sreset_out,
    input idle_mode_e        mode_q,
    input logic              auto_q
);
    p_defaults_in_srst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_out |-> (mode_q == MODE_RST && auto_q == AUTO_RST));

    p_srst_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sreset_out) |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_CFG) && reg_wdata[SRST_BIT]));

    p_status_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sreset_out && reg_rd && reg_addr == ADDR_W'(OFS_STAT)) |-> reg_rdata == 32'h0);

    p_never_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == IM_NEVER) |=> !idle_ack);

    p_quiet_before_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q[1]) && idle_ack) |-> $past(!(reg_wr || reg_rd || busy_in || sreset_out)));

    p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> idle_req);

    p_gate_fall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_en) |-> $past(!(reg_wr || reg_rd)));

    p_gate_free_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_q |-> gate_en);
endmodule

bind pwr_idle_ctrl pic_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .idle_req(idle_req), .idle_ack(idle_ack), .busy_in(busy_in),
    .gate_en(gate_en), .sreset_out(sreset_out), .mode_q(mode_q), .auto_q(auto_q)
);

// File: tb/tb_pwr_idle_ctrl.sv
`timescale 1ns/100ps
module tb_pwr_idle_ctrl;
    localparam int          ADDR_W = 8;
    localparam logic [31:0] REV    = 32'h0003_0102;
    localparam int          SRST   = 8;
    localparam logic [7:0]  A_REV = 8'h00, A_CFG = 8'h10, A_STAT = 8'h14;

    // {write data, expected read-back} for the configuration word (R2)
    localparam logic [63:0] CFG_VEC [0:5] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFF9, 32'h0000_0019},
        {32'h0000_0008, 32'h0000_0008},
        {32'h0000_001C, 32'h0000_0018},
        {32'hFFFF_FFE1, 32'h0000_0001},
        {32'h0000_0011, 32'h0000_0011}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, idle_req = 0, busy_in = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, v;
    logic idle_ack, gate_en, sreset_out;
    int n_chk = 0, n_fail = 0, srst_seen = 0;

    always #2.5 clk = ~clk;

    pwr_idle_ctrl #(.ADDR_W(ADDR_W), .REV_ID(REV), .SRST_CYCLES(SRST), .GATE_QUIET(2)) dut (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .idle_req, .idle_ack, .busy_in, .gate_en, .sreset_out
    );

    always @(negedge clk) if (sreset_out === 1'b1) srst_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic ack_is(input logic e, input string req);
        #1 chk(idle_ack === e, req, {31'b0, idle_ack}, {31'b0, e});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1 chk(gate_en === 1 && idle_ack === 0 && sreset_out === 0, "R1",
               {29'b0, gate_en, idle_ack, sreset_out}, 32'h4);
        @(negedge clk);
        do_read(A_CFG, v);  chk(v === 32'h11, "R1", v, 32'h11);
        do_read(A_STAT, v); chk(v === 32'h1, "R1", v, 32'h1);
        do_read(A_REV, v);  chk(v === REV, "R1", v, REV);

        // R2: table walk
        for (int i = 0; i < 6; i++) begin
            do_write(A_CFG, CFG_VEC[i][63:32]);
            do_read(A_CFG, v);
            chk(v === CFG_VEC[i][31:0], "R2", v, CFG_VEC[i][31:0]);
        end

        // R3: writes elsewhere are ignored
        do_write(A_STAT, 32'h0);
        do_write(A_REV, 32'h0);
        do_write(8'h20, 32'h2);
        #1 chk(sreset_out === 0, "R3", {31'b0, sreset_out}, 0);
        @(negedge clk);
        do_read(A_CFG, v);  chk(v === 32'h11, "R3", v, 32'h11);
        do_read(A_REV, v);  chk(v === REV, "R3", v, REV);
        do_read(8'h08, v);  chk(v === 32'h0, "R3", v, 0);

        // R4/R5: software reset sequence
        do_write(A_CFG, 32'h0);
        srst_seen = 0;
        do_write(A_CFG, 32'h0000_0007);
        do_read(A_STAT, v); chk(v === 32'h0, "R5", v, 0);
        do_read(A_CFG, v);  chk(v === 32'h11, "R4", v, 32'h11);
        do_write(A_CFG, 32'h0000_0008);
        repeat (10) @(negedge clk);
        chk(srst_seen == SRST, "R4", srst_seen, SRST);
        do_read(A_STAT, v); chk(v === 32'h1, "R5", v, 1);
        do_read(A_CFG, v);  chk(v === 32'h11, "R5", v, 32'h11);

        // R6: unconditional policy ignores busy
        do_write(A_CFG, 32'h0);
        busy_in = 1; idle_req = 1;
        ack_is(0, "R6");
        @(negedge clk); ack_is(1, "R6");
        @(negedge clk); idle_req = 0; ack_is(0, "R10");
        @(negedge clk); busy_in = 0;

        // R7: never acknowledges
        do_write(A_CFG, 32'h8);
        idle_req = 1;
        for (int i = 0; i < 5; i++) begin
            ack_is(0, "R7");
            @(negedge clk);
        end
        idle_req = 0;
        @(negedge clk);

        // R8: activity-based policy
        do_write(A_CFG, 32'h10);
        idle_req = 1;
        ack_is(0, "R8");
        @(negedge clk); ack_is(0, "R8");
        @(negedge clk); ack_is(1, "R8");
        @(negedge clk); busy_in = 1; ack_is(1, "R8");
        @(negedge clk); busy_in = 0; ack_is(0, "R8");
        @(negedge clk); ack_is(0, "R8");
        @(negedge clk); ack_is(1, "R8");
        @(negedge clk); idle_req = 0; ack_is(0, "R10");
        @(negedge clk);

        // R9: spare encoding behaves as activity-based
        do_write(A_CFG, 32'hFFFF_FFF9);
        do_read(A_CFG, v); chk(v === 32'h19, "R9", v, 32'h19);
        idle_req = 1;
        ack_is(0, "R9");
        @(negedge clk); ack_is(0, "R9");
        @(negedge clk); ack_is(1, "R9");
        @(negedge clk); idle_req = 0; ack_is(0, "R10");
        @(negedge clk);

        // R11: gating enable (auto-gating is set)
        reg_rd = 1; reg_addr = A_CFG;
        #1 chk(gate_en === 1, "R11", {31'b0, gate_en}, 1);
        @(negedge clk); reg_rd = 0;
        #1 chk(gate_en === 1, "R11", {31'b0, gate_en}, 1);
        @(negedge clk); #1 chk(gate_en === 1, "R11", {31'b0, gate_en}, 1);
        @(negedge clk); #1 chk(gate_en === 0, "R11", {31'b0, gate_en}, 0);
        @(negedge clk); #1 chk(gate_en === 0, "R11", {31'b0, gate_en}, 0);
        @(negedge clk); reg_rd = 1;
        #1 chk(gate_en === 1, "R11", {31'b0, gate_en}, 1);
        @(negedge clk); reg_rd = 0;
        do_write(A_CFG, 32'h10);
        repeat (4) @(negedge clk);
        #1 chk(gate_en === 1, "R11", {31'b0, gate_en}, 1);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule